// File: doc/BRIEF.md
# Per-Register Vector Length Calculator

This block keeps, for each of two register banks (integer and floating-point), a table with one entry per architectural register. Each entry holds a 4-bit vector length and a 3-bit element-width code. A configuration write port updates one field of one entry per cycle. The block also drives a per-register "is vector" bit for each bank so that instruction decode can tell scalar registers from vector registers with one bit test.

The block also serves a set-vector-length request. The request names a register index, a bank and a requested length. From that register's table entry the block computes how many packed elements of the configured width fit into one XLEN-wide register. It scales the stored length by that factor and returns the smallest of the scaled length, XLEN and the requested length. The result is registered, so it is available one cycle after the request. XLEN is a parameter (32 or 64), and the maximum vector depth equals XLEN.

Top module: `vlen_calc`

## Requirements
- R1: After synchronous reset, every entry in both banks holds length 1 and width code 000. Both is-vector vectors read all zero, and `cfg_illegal` and `rsp_valid` are 0.
- R2: A legal write with `cfg_field`=0 stores `cfg_data[3:0]` as the length of register `cfg_idx` in bank `cfg_bank` (0 = integer, 1 = floating-point). From the cycle after the write edge, that register's is-vector bit is 1 exactly when the stored length is not 1.
- R3: A write of length 0 is reserved. It leaves the entry unchanged and raises `cfg_illegal` for the one cycle after the write edge.
- R4: A write with `cfg_field`=1 stores `cfg_data[2:0]` as the width code, and `cfg_data[3]` is ignored. Codes 110 and 111 are reserved: such a write leaves the entry unchanged and raises `cfg_illegal` for one cycle.
- R5: The width codes are 000 = full register, 001 = 8, 010 = 16, 011 = 32, 100 = 64 and 101 = 128 bits. The packing factor is XLEN divided by the element width, and code 000 gives a factor of 1.
- R6: The cycle after a request edge, `rsp_valid` is 1 and `rsp_len` equals min(length × factor, XLEN, `req_len`). The length and width used are those of the entry selected by `req_idx` and `req_bank`.
- R7: If the element width is wider than XLEN, the factor is 0. In that case the response carries `rsp_illegal`=1 and `rsp_len`=0.
- R8: The two banks are independent. A write to one bank changes neither the other bank's entries nor its is-vector bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_bank | input | 1 | Bank of the write: 0 integer, 1 floating-point |
| cfg_field | input | 1 | Field written: 0 length, 1 width code |
| cfg_idx | input | 5 | Register index written |
| cfg_data | input | 4 | Write data (length in [3:0], width code in [2:0]) |
| cfg_illegal | output | 1 | Previous-cycle write was to a reserved value |
| req_valid | input | 1 | Set-vector-length request |
| req_bank | input | 1 | Bank of the request register |
| req_idx | input | 5 | Request register index |
| req_len | input | XLEN | Requested length operand |
| rsp_valid | output | 1 | Response valid |
| rsp_len | output | clog2(XLEN+1) | Effective vector length |
| rsp_illegal | output | 1 | Element width exceeds XLEN |
| int_is_vec | output | 32 | Integer bank is-vector bits |
| fp_is_vec | output | 32 | Floating-point bank is-vector bits |

## Verification
Table writes take effect at the write edge. The is-vector bits and `cfg_illegal` therefore change one edge after the write is driven, and a response is due one edge after its request. Every bench task drives its inputs on a falling edge, lets exactly one rising edge pass, and samples on the following falling edge. Writes and requests are never driven in the same cycle, so each response reflects only table state that is already settled.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
    localparam int NREG  = 32;
    localparam int IDX_W = $clog2(NREG);
    localparam int LEN_W = 4;
    localparam int EW_W  = 3;
    localparam int NBANK = 2;

    typedef enum logic { BANK_INT = 1'b0, BANK_FP = 1'b1 } bank_e;
    typedef enum logic { FLD_LEN = 1'b0, FLD_EW = 1'b1 } field_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [EW_W-1:0]  ew;
    } entry_t;

    localparam entry_t ENTRY_RST = '{len: LEN_W'(1), ew: '0};

    function automatic logic cfg_is_reserved(field_e fld, logic [LEN_W-1:0] d);
        if (fld == FLD_LEN) return (d == '0);
        return (d[2:1] == 2'b11);
    endfunction
endpackage

// File: rtl/vlc_reg_table.sv
module vlc_reg_table
    import vlc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  field_e           fld,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [LEN_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output entry_t           rd_entry,
    output logic [NREG-1:0]  is_vec
);
    entry_t tbl_q [NREG];
    logic   bad;

    assign bad = cfg_is_reserved(fld, wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) tbl_q[i] <= ENTRY_RST;
        end else if (we && !bad) begin
            if (fld == FLD_LEN) tbl_q[wr_idx].len <= wr_data;
            else                tbl_q[wr_idx].ew  <= wr_data[EW_W-1:0];
        end
    end

    assign rd_entry = tbl_q[rd_idx];

    for (genvar g = 0; g < NREG; g++) begin : g_vec
        assign is_vec[g] = (tbl_q[g].len != LEN_W'(1));
    end

    assert_bad_len_keeps_R3: assert property (@(posedge clk) disable iff (rst)
        (we && fld == FLD_LEN && wr_data == '0) |=> tbl_q[$past(wr_idx)].len == $past(tbl_q[wr_idx].len));

    assert_bad_ew_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        (we && fld == FLD_EW && wr_data[2:1] == 2'b11) |=> tbl_q[$past(wr_idx)].ew == $past(tbl_q[wr_idx].ew));

    assert_scalar_bit_R2: assert property (@(posedge clk) disable iff (rst)
        (we && fld == FLD_LEN && wr_data == LEN_W'(1)) |=> !is_vec[$past(wr_idx)]);
endmodule

// File: rtl/vlc_len_unit.sv
module vlc_len_unit
    import vlc_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int RW  = $clog2(XLEN + 1),
    localparam int PW  = LEN_W + $clog2(XLEN) + 1
)(
    input  entry_t            ent,
    input  logic [XLEN-1:0]   req_len,
    output logic [RW-1:0]     eff_len,
    output logic              too_wide
);
    logic [PW-1:0] mult;
    logic [PW-1:0] prod;
    logic [PW-1:0] cap;

    // element bits = 8 << (code-1), so factor = XLEN >> (code+2); 0 when too wide
    always_comb begin
        if (ent.ew == '0) mult = PW'(1);
        else              mult = PW'(XLEN) >> ({2'b00, ent.ew} + 5'd2);
        prod = PW'(ent.len) * mult;
        cap  = (prod > PW'(XLEN)) ? PW'(XLEN) : prod;
        if (req_len < XLEN'(cap)) cap = PW'(req_len);
        too_wide = (mult == '0);
        eff_len  = too_wide ? '0 : RW'(cap);
    end
endmodule

// File: rtl/vlen_calc.sv
module vlen_calc
    import vlc_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int RW  = $clog2(XLEN + 1)
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic            cfg_bank,
    input  logic            cfg_field,
    input  logic [4:0]      cfg_idx,
    input  logic [3:0]      cfg_data,
    output logic            cfg_illegal,
    input  logic            req_valid,
    input  logic            req_bank,
    input  logic [4:0]      req_idx,
    input  logic [XLEN-1:0] req_len,
    output logic            rsp_valid,
    output logic [RW-1:0]   rsp_len,
    output logic            rsp_illegal,
    output logic [31:0]     int_is_vec,
    output logic [31:0]     fp_is_vec
);
    entry_t          rd_ent [NBANK];
    logic [NREG-1:0] vec_b  [NBANK];
    entry_t          sel_ent;
    logic [RW-1:0]   eff;
    logic            wide;
    field_e          fld;

    assign fld = field_e'(cfg_field);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        vlc_reg_table u_tbl (
            .clk      (clk),
            .rst      (rst),
            .we       (cfg_we && (cfg_bank == b[0])),
            .fld      (fld),
            .wr_idx   (cfg_idx),
            .wr_data  (cfg_data),
            .rd_idx   (req_idx),
            .rd_entry (rd_ent[b]),
            .is_vec   (vec_b[b])
        );
    end

    assign sel_ent    = rd_ent[req_bank];
    assign int_is_vec = vec_b[BANK_INT];
    assign fp_is_vec  = vec_b[BANK_FP];

    vlc_len_unit #(.XLEN(XLEN)) u_len (
        .ent      (sel_ent),
        .req_len  (req_len),
        .eff_len  (eff),
        .too_wide (wide)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_len     <= '0;
            rsp_illegal <= 1'b0;
            cfg_illegal <= 1'b0;
        end else begin
            rsp_valid   <= req_valid;
            cfg_illegal <= cfg_we && cfg_is_reserved(fld, cfg_data);
            if (req_valid) begin
                rsp_len     <= eff;
                rsp_illegal <= wide;
            end
        end
    end

    assert_rsp_bounded_R6: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (XLEN'(rsp_len) <= $past(req_len)) && (rsp_len <= RW'(XLEN)));

    assert_wide_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_illegal) |-> rsp_len == '0);

    assert_illegal_needs_write_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_illegal |-> $past(cfg_we));

    assert_reset_scalar_R1: assert property (@(posedge clk)
        $past(rst) |-> (int_is_vec == '0 && fp_is_vec == '0 && !rsp_valid));
endmodule

// File: tb/vlen_calc_tb_top.sv
module vlen_calc_tb_top;
    localparam int XLEN = 32;
    localparam int RW   = $clog2(XLEN + 1);

    logic clk = 1'b0;
    logic rst;
    logic cfg_we, cfg_bank, cfg_field;
    logic [4:0] cfg_idx;
    logic [3:0] cfg_data;
    logic cfg_illegal;
    logic req_valid, req_bank;
    logic [4:0] req_idx;
    logic [XLEN-1:0] req_len;
    logic rsp_valid, rsp_illegal;
    logic [RW-1:0] rsp_len;
    logic [31:0] int_is_vec, fp_is_vec;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    vlen_calc #(.XLEN(XLEN)) dut_i (.*);

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(bit bank, bit field, int idx, int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bank = bank; cfg_field = field;
        cfg_idx = 5'(idx); cfg_data = 4'(data);
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rq(bit bank, int idx, int len, string req, int exp_len, int exp_ill);
        @(negedge clk);
        req_valid = 1'b1; req_bank = bank; req_idx = 5'(idx); req_len = XLEN'(len);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, int'(rsp_valid), 1);
        check({req, " len"}, int'(rsp_len), exp_len);
        check({req, " illegal"}, int'(rsp_illegal), exp_ill);
    endtask

    task automatic t_reset;
        check("R1 int_is_vec", int'(int_is_vec), 0);
        check("R1 fp_is_vec", int'(fp_is_vec), 0);
        check("R1 cfg_illegal", int'(cfg_illegal), 0);
        check("R1 rsp_valid", int'(rsp_valid), 0);
        rq(1'b0, 5, 100, "R1 default len", 1, 0);
        rq(1'b1, 31, 100, "R1 default fp len", 1, 0);
    endtask

    task automatic t_len_write;
        wr(1'b0, 1'b0, 3, 4);
        check("R2 is_vec r3", int'(int_is_vec[3]), 1);
        check("R2 cfg_illegal", int'(cfg_illegal), 0);
        rq(1'b0, 3, 100, "R6 len4", 4, 0);
        rq(1'b0, 3, 2, "R6 req caps", 2, 0);
    endtask

    task automatic t_widths;
        wr(1'b0, 1'b1, 3, 1);
        rq(1'b0, 3, 100, "R5 ew8", 16, 0);
        wr(1'b0, 1'b1, 3, 2);
        rq(1'b0, 3, 100, "R5 ew16", 8, 0);
        wr(1'b0, 1'b1, 3, 3);
        rq(1'b0, 3, 100, "R5 ew32", 4, 0);
        wr(1'b0, 1'b1, 3, 4'b1010);  // bit 3 ignored: code 010
        rq(1'b0, 3, 100, "R4 data bit3 ignored", 8, 0);
        wr(1'b0, 1'b0, 3, 15);
        wr(1'b0, 1'b1, 3, 1);
        rq(1'b0, 3, 100, "R6 capped at XLEN", 32, 0);
        rq(1'b0, 3, 17, "R6 req below XLEN", 17, 0);
    endtask

    task automatic t_too_wide;
        wr(1'b0, 1'b1, 3, 4);
        rq(1'b0, 3, 100, "R7 ew64", 0, 1);
        wr(1'b0, 1'b1, 3, 5);
        rq(1'b0, 3, 100, "R7 ew128", 0, 1);
    endtask

    task automatic t_reserved;
        wr(1'b0, 1'b1, 3, 3);       // ew32 -> factor 1, len 15
        wr(1'b0, 1'b0, 3, 0);
        check("R3 cfg_illegal len0", int'(cfg_illegal), 1);
        rq(1'b0, 3, 100, "R3 len kept", 15, 0);
        check("R3 illegal one cycle", int'(cfg_illegal), 0);
        wr(1'b0, 1'b1, 3, 6);
        check("R4 cfg_illegal code6", int'(cfg_illegal), 1);
        rq(1'b0, 3, 100, "R4 code kept", 15, 0);
        wr(1'b0, 1'b1, 3, 7);
        check("R4 cfg_illegal code7", int'(cfg_illegal), 1);
        rq(1'b0, 3, 100, "R4 code7 kept", 15, 0);
    endtask

    task automatic t_banks;
        wr(1'b1, 1'b0, 3, 2);
        check("R8 fp is_vec", int'(fp_is_vec), 32'h8);
        rq(1'b1, 3, 100, "R8 fp len", 2, 0);
        rq(1'b0, 3, 100, "R8 int untouched", 15, 0);
        wr(1'b0, 1'b0, 3, 1);
        check("R2 back to scalar", int'(int_is_vec), 0);
        check("R8 fp bit kept", int'(fp_is_vec), 32'h8);
        wr(1'b1, 1'b0, 31, 9);
        check("R2 fp r31", int'(fp_is_vec), 32'h8000_0008);
    endtask

    initial begin
        cfg_we = 0; cfg_bank = 0; cfg_field = 0; cfg_idx = 0; cfg_data = 0;
        req_valid = 0; req_bank = 0; req_idx = 0; req_len = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_len_write();
        t_widths();
        t_too_wide();
        t_reserved();
        t_banks();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule